// File: doc/BRIEF.md
# Critical Word Split Line Controller

This block sits between the miss port of a last-level cache and two independent memory channel request ports. One channel is fast with low latency, the other is slow and spends less energy. Each cache line is striped across the two: word 0, the critical word, is held by the fast channel, and words 1 to 7 are held by the slow channel. A line read is therefore split into one read on each channel.

The fast response is sent on to the requester the cycle after it arrives, without waiting for the rest of the line. The slow channel returns its seven words as one contiguous burst. The controller reassembles each line by tag, in whatever order the two channels answer. It reports the full line once both halves are in. A line write is split the same way and is acknowledged once both channels have taken their half.

Up to eight misses may be outstanding. The tag of a miss is the index of the table entry it occupies, and the controller hands that tag back to the requester when it accepts the miss.

Top module: `cwsl_split_ctrl`

## Requirements
- R1: A miss accepted at a clock edge (miss_valid and miss_ready both high) raises fast_req_valid from the next cycle. The request carries the tag, the address, the write flag (1 = write) and bits 63:0 of the line as write data. It stays unchanged until the cycle in which fast_req_ready is high.
- R2: The same accepted miss also raises slow_req_valid from the next cycle. This request carries the same tag, address and write flag, with bits 511:64 of the line as write data, and is held the same way until slow_req_ready. Each miss yields exactly one request per channel.
- R3: A fast response sampled at an edge appears on crit_valid, crit_tag and crit_data for the following cycle only.
- R4: A slow read response is a burst of 7 back-to-back beats with one tag. Beat k (counting from 0) fills word k+1 of the line, found at done_line bits 64(k+1)+63 down to 64(k+1).
- R5: A read is reported on done_valid (for one cycle, with done_write 0) only after both its fast response and its last slow beat have been sampled, and no earlier than one cycle after its critical word was shown. done_line bits 63:0 hold the fast word.
- R6: Responses from the two channels may come in any order, both relative to each other and across tags. Each one is matched to its line by tag alone.
- R7: A write is reported on done_valid with done_write 1 and done_line all zero. This happens only after both its fast and its slow request have been accepted.
- R8: While all 8 tags are in use, miss_ready is low. A tag is free again from the cycle its completion is shown on done_valid.
- R9: miss_tag shows the lowest-numbered free tag, and that is the tag an accepted miss receives.
- R10: After reset, no request, critical word or completion is valid, and miss_ready is high.
- R11: When several lines are complete, one is reported per cycle, lowest tag first. The reported line appears on done_valid in the cycle after the one in which it became eligible (or later, if a lower tag goes first).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Miss request can be taken this cycle |
| miss_write | input | 1 | 1 = line write, 0 = line read |
| miss_addr | input | 40 | Line address |
| miss_wdata | input | 512 | Line data for a write, word 0 in bits 63:0 |
| miss_tag | output | 3 | Tag given to a miss accepted this cycle |
| fast_req_valid | output | 1 | Fast channel request valid |
| fast_req_ready | input | 1 | Fast channel accepts the request |
| fast_req_write | output | 1 | Fast request is a write |
| fast_req_tag | output | 3 | Fast request tag |
| fast_req_addr | output | 40 | Fast request line address |
| fast_req_wdata | output | 64 | Critical word to write |
| fast_rsp_valid | input | 1 | Fast read data returned |
| fast_rsp_tag | input | 3 | Tag of the fast read data |
| fast_rsp_data | input | 64 | Critical word read |
| slow_req_valid | output | 1 | Slow channel request valid |
| slow_req_ready | input | 1 | Slow channel accepts the request |
| slow_req_write | output | 1 | Slow request is a write |
| slow_req_tag | output | 3 | Slow request tag |
| slow_req_addr | output | 40 | Slow request line address |
| slow_req_wdata | output | 448 | Words 1 to 7 to write |
| slow_rsp_valid | input | 1 | Slow burst beat valid |
| slow_rsp_tag | input | 3 | Tag of the burst |
| slow_rsp_data | input | 64 | One word of the burst |
| crit_valid | output | 1 | Critical word delivered early |
| crit_tag | output | 3 | Tag of the critical word |
| crit_data | output | 64 | Critical word |
| done_valid | output | 1 | Line read complete or write acknowledged |
| done_write | output | 1 | Completion is a write acknowledgement |
| done_tag | output | 3 | Tag of the completed miss |
| done_line | output | 512 | Assembled line (zero for writes) |

## Verification
Most faults inside the table show up within a cycle or two at the ports. A done bit that is set wrongly or lost makes done_valid come early, late or never. A bad tag index lands a word in another line's slot, so done_line differs from the address-derived pattern in one word when that line is reported. A beat counter that slips moves every slow word by one position. A busy bit that is never cleared lowers miss_ready or changes miss_tag on the next miss. The reference model in the bench predicts every output on every cycle, so such a fault is caught in the first cycle in which the outputs differ, which is usually the cycle of the completion concerned.

// File: rtl/cwsl_pkg.sv
package cwsl_pkg;

    typedef enum logic {
        CWSL_RD = 1'b0,
        CWSL_WR = 1'b1
    } cwsl_op_e;

    // Width of an index into n items, never below one bit.
    function automatic int unsigned cwsl_idx_w(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cwsl_first_set.sv
// Finds the lowest set bit of a vector.
module cwsl_first_set #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = 3
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/cwsl_beat_ctr.sv
// Position inside the slow channel burst; wraps after the last beat.
module cwsl_beat_ctr #(
    parameter int unsigned BEATS  = 7,
    parameter int unsigned BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_i,
    output logic [BEAT_W-1:0] idx_o,
    output logic              last_o
);
    logic [BEAT_W-1:0] cnt_d, cnt_q;

    assign idx_o  = cnt_q;
    assign last_o = (cnt_q == BEAT_W'(BEATS - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (beat_i) begin
            cnt_d = last_o ? '0 : cnt_q + BEAT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cwsl_split_ctrl.sv
module cwsl_split_ctrl
    import cwsl_pkg::*;
#(
    parameter int unsigned WORD_W     = 64,
    parameter int unsigned LINE_WORDS = 8,
    parameter int unsigned NUM_TAGS   = 8,
    parameter int unsigned ADDR_W     = 40,
    localparam int unsigned TAG_W      = cwsl_idx_w(NUM_TAGS),
    localparam int unsigned SLOW_WORDS = LINE_WORDS - 1,
    localparam int unsigned LINE_W     = WORD_W * LINE_WORDS,
    localparam int unsigned SLOW_W     = WORD_W * SLOW_WORDS,
    localparam int unsigned BEAT_W     = cwsl_idx_w(SLOW_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic              miss_write,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic [LINE_W-1:0] miss_wdata,
    output logic [TAG_W-1:0]  miss_tag,
    output logic              fast_req_valid,
    input  logic              fast_req_ready,
    output logic              fast_req_write,
    output logic [TAG_W-1:0]  fast_req_tag,
    output logic [ADDR_W-1:0] fast_req_addr,
    output logic [WORD_W-1:0] fast_req_wdata,
    input  logic              fast_rsp_valid,
    input  logic [TAG_W-1:0]  fast_rsp_tag,
    input  logic [WORD_W-1:0] fast_rsp_data,
    output logic              slow_req_valid,
    input  logic              slow_req_ready,
    output logic              slow_req_write,
    output logic [TAG_W-1:0]  slow_req_tag,
    output logic [ADDR_W-1:0] slow_req_addr,
    output logic [SLOW_W-1:0] slow_req_wdata,
    input  logic              slow_rsp_valid,
    input  logic [TAG_W-1:0]  slow_rsp_tag,
    input  logic [WORD_W-1:0] slow_rsp_data,
    output logic              crit_valid,
    output logic [TAG_W-1:0]  crit_tag,
    output logic [WORD_W-1:0] crit_data,
    output logic              done_valid,
    output logic              done_write,
    output logic [TAG_W-1:0]  done_tag,
    output logic [LINE_W-1:0] done_line
);
    localparam int unsigned WIDX_W = cwsl_idx_w(LINE_WORDS);

    typedef logic [LINE_WORDS-1:0][WORD_W-1:0] line_t;

    typedef struct packed {
        logic     busy;
        cwsl_op_e op;
        logic     fast_done;
        logic     slow_done;
        line_t    words;
    } entry_t;

    typedef struct packed {
        logic              vld;
        cwsl_op_e          op;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wd;
    } fast_req_t;

    typedef struct packed {
        logic              vld;
        cwsl_op_e          op;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
        logic [SLOW_W-1:0] wd;
    } slow_req_t;

    typedef struct packed {
        entry_t [NUM_TAGS-1:0] ent;
        fast_req_t             fq;
        slow_req_t             sq;
        logic                  cv;
        logic [TAG_W-1:0]      ct;
        logic [WORD_W-1:0]     cd;
        logic                  dv;
        logic                  dw;
        logic [TAG_W-1:0]      dt;
        line_t                 dl;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_TAGS-1:0] free_vec, cmpl_vec;
    logic                free_found, cmpl_found;
    logic [TAG_W-1:0]    free_idx, cmpl_idx;
    logic [BEAT_W-1:0]   beat_idx;
    logic                beat_last;
    logic [WIDX_W-1:0]   slot;
    logic                accept;

    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_flags
        assign free_vec[g] = !st_q.ent[g].busy;
        assign cmpl_vec[g] = st_q.ent[g].busy && st_q.ent[g].fast_done && st_q.ent[g].slow_done;
    end

    cwsl_first_set #(.N(NUM_TAGS), .IW(TAG_W)) u_free_pick (
        .vec_i  (free_vec),
        .found_o(free_found),
        .idx_o  (free_idx)
    );

    cwsl_first_set #(.N(NUM_TAGS), .IW(TAG_W)) u_cmpl_pick (
        .vec_i  (cmpl_vec),
        .found_o(cmpl_found),
        .idx_o  (cmpl_idx)
    );

    cwsl_beat_ctr #(.BEATS(SLOW_WORDS), .BEAT_W(BEAT_W)) u_beats (
        .clk   (clk),
        .rst_n (rst_n),
        .beat_i(slow_rsp_valid),
        .idx_o (beat_idx),
        .last_o(beat_last)
    );

    assign miss_ready = free_found
                      && (!st_q.fq.vld || fast_req_ready)
                      && (!st_q.sq.vld || slow_req_ready);
    assign miss_tag   = free_idx;
    assign accept     = miss_valid && miss_ready;
    assign slot       = WIDX_W'(beat_idx) + WIDX_W'(1);

    always_comb begin
        st_d = st_q;

        // One completion per cycle, lowest tag first.
        st_d.dv = cmpl_found;
        st_d.dt = cmpl_idx;
        st_d.dw = st_q.ent[cmpl_idx].op == CWSL_WR;
        st_d.dl = (st_q.ent[cmpl_idx].op == CWSL_WR) ? '0 : st_q.ent[cmpl_idx].words;
        if (cmpl_found) begin
            st_d.ent[cmpl_idx].busy      = 1'b0;
            st_d.ent[cmpl_idx].fast_done = 1'b0;
            st_d.ent[cmpl_idx].slow_done = 1'b0;
        end

        // Request handshakes; a write half is done once taken.
        if (st_q.fq.vld && fast_req_ready) begin
            st_d.fq.vld = 1'b0;
            if (st_q.fq.op == CWSL_WR) st_d.ent[st_q.fq.tag].fast_done = 1'b1;
        end
        if (st_q.sq.vld && slow_req_ready) begin
            st_d.sq.vld = 1'b0;
            if (st_q.sq.op == CWSL_WR) st_d.ent[st_q.sq.tag].slow_done = 1'b1;
        end

        // New miss: claim an entry and load both channel requests.
        if (accept) begin
            st_d.ent[free_idx].busy      = 1'b1;
            st_d.ent[free_idx].op        = cwsl_op_e'(miss_write);
            st_d.ent[free_idx].fast_done = 1'b0;
            st_d.ent[free_idx].slow_done = 1'b0;
            st_d.fq.vld  = 1'b1;
            st_d.fq.op   = cwsl_op_e'(miss_write);
            st_d.fq.tag  = free_idx;
            st_d.fq.addr = miss_addr;
            st_d.fq.wd   = miss_wdata[WORD_W-1:0];
            st_d.sq.vld  = 1'b1;
            st_d.sq.op   = cwsl_op_e'(miss_write);
            st_d.sq.tag  = free_idx;
            st_d.sq.addr = miss_addr;
            st_d.sq.wd   = miss_wdata[LINE_W-1:WORD_W];
        end

        // Critical word: pass on at once and keep a copy for the line.
        st_d.cv = fast_rsp_valid;
        st_d.ct = fast_rsp_tag;
        st_d.cd = fast_rsp_data;
        if (fast_rsp_valid) begin
            st_d.ent[fast_rsp_tag].words[0]  = fast_rsp_data;
            st_d.ent[fast_rsp_tag].fast_done = 1'b1;
        end

        // Slow burst beats fill words 1 upward.
        if (slow_rsp_valid) begin
            st_d.ent[slow_rsp_tag].words[slot] = slow_rsp_data;
            if (beat_last) st_d.ent[slow_rsp_tag].slow_done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fast_req_valid = st_q.fq.vld;
    assign fast_req_write = st_q.fq.op == CWSL_WR;
    assign fast_req_tag   = st_q.fq.tag;
    assign fast_req_addr  = st_q.fq.addr;
    assign fast_req_wdata = st_q.fq.wd;
    assign slow_req_valid = st_q.sq.vld;
    assign slow_req_write = st_q.sq.op == CWSL_WR;
    assign slow_req_tag   = st_q.sq.tag;
    assign slow_req_addr  = st_q.sq.addr;
    assign slow_req_wdata = st_q.sq.wd;
    assign crit_valid     = st_q.cv;
    assign crit_tag       = st_q.ct;
    assign crit_data      = st_q.cd;
    assign done_valid     = st_q.dv;
    assign done_write     = st_q.dw;
    assign done_tag       = st_q.dt;
    assign done_line      = st_q.dl;
endmodule

// File: rtl/cwsl_split_ctrl_chk.sv
module cwsl_split_ctrl_chk #(
    parameter int unsigned NUM_TAGS = 8,
    parameter int unsigned TAG_W    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             miss_valid,
    input logic             miss_ready,
    input logic             fast_req_valid,
    input logic             fast_req_ready,
    input logic [TAG_W-1:0] fast_req_tag,
    input logic             slow_req_valid,
    input logic             slow_req_ready,
    input logic [TAG_W-1:0] slow_req_tag,
    input logic             fast_rsp_valid,
    input logic [TAG_W-1:0] fast_rsp_tag,
    input logic             crit_valid,
    input logic [TAG_W-1:0] crit_tag,
    input logic             done_valid,
    input logic             done_write,
    input logic [TAG_W-1:0] done_tag
);
    localparam int unsigned CW = TAG_W + 2;

    logic [CW-1:0] open_q;
    logic [CW-1:0] in_use;
    logic          took;

    assign took   = miss_valid && miss_ready;
    assign in_use = open_q - CW'(done_valid);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  open_q <= '0;
        else if (took && !done_valid) open_q <= open_q + CW'(1);
        else if (!took && done_valid) open_q <= open_q - CW'(1);
    end

    AST_FAST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fast_req_valid && !fast_req_ready |=> fast_req_valid && fast_req_tag == $past(fast_req_tag)); // R1
    AST_SLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        slow_req_valid && !slow_req_ready |=> slow_req_valid && slow_req_tag == $past(slow_req_tag)); // R2
    AST_CRIT_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        fast_rsp_valid |=> crit_valid && crit_tag == $past(fast_rsp_tag)); // R3
    AST_CRIT_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && !done_write |-> !(crit_valid && crit_tag == done_tag)); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        miss_ready |-> in_use < CW'(NUM_TAGS)); // R8
endmodule

bind cwsl_split_ctrl cwsl_split_ctrl_chk #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .miss_ready    (miss_ready),
    .fast_req_valid(fast_req_valid),
    .fast_req_ready(fast_req_ready),
    .fast_req_tag  (fast_req_tag),
    .slow_req_valid(slow_req_valid),
    .slow_req_ready(slow_req_ready),
    .slow_req_tag  (slow_req_tag),
    .fast_rsp_valid(fast_rsp_valid),
    .fast_rsp_tag  (fast_rsp_tag),
    .crit_valid    (crit_valid),
    .crit_tag      (crit_tag),
    .done_valid    (done_valid),
    .done_write    (done_write),
    .done_tag      (done_tag)
);

// File: tb/cwsl_split_ctrl_tb_top.sv
`timescale 1ns/1ps
module cwsl_split_ctrl_tb_top;
    localparam int NT = 8;
    localparam int TW = 3;
    localparam int AW = 40;
    localparam int LINEW = 512;
    localparam int SW = 448;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n;
    logic             miss_valid, miss_ready, miss_write;
    logic [AW-1:0]    miss_addr;
    logic [LINEW-1:0] miss_wdata;
    logic [TW-1:0]    miss_tag;
    logic             fast_req_valid, fast_req_ready, fast_req_write;
    logic [TW-1:0]    fast_req_tag;
    logic [AW-1:0]    fast_req_addr;
    logic [63:0]      fast_req_wdata;
    logic             fast_rsp_valid;
    logic [TW-1:0]    fast_rsp_tag;
    logic [63:0]      fast_rsp_data;
    logic             slow_req_valid, slow_req_ready, slow_req_write;
    logic [TW-1:0]    slow_req_tag;
    logic [AW-1:0]    slow_req_addr;
    logic [SW-1:0]    slow_req_wdata;
    logic             slow_rsp_valid;
    logic [TW-1:0]    slow_rsp_tag;
    logic [63:0]      slow_rsp_data;
    logic             crit_valid;
    logic [TW-1:0]    crit_tag;
    logic [63:0]      crit_data;
    logic             done_valid, done_write;
    logic [TW-1:0]    done_tag;
    logic [LINEW-1:0] done_line;

    cwsl_split_ctrl dut_i (.*);

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(bit ok, string req, logic [LINEW-1:0] act, logic [LINEW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(logic [AW-1:0] a, int w);
        if (w == 0) return {a[31:0], 32'hF0F0_0000};
        return {a[31:0] ^ 32'h5A5A_0000, 24'h0, 8'(w)};
    endfunction

    function automatic logic [LINEW-1:0] line_of(logic [AW-1:0] a);
        logic [LINEW-1:0] l;
        for (int w = 0; w < 8; w++) l[w*64 +: 64] = pat(a, w);
        return l;
    endfunction

    // Reference model state
    bit            m_busy[NT], m_wr[NT], m_fd[NT], m_sd[NT];
    logic [AW-1:0] m_addr[NT];
    bit            mf_vld, mf_wr, ms_vld, ms_wr;
    int            mf_tag, ms_tag;
    logic [AW-1:0] mf_addr, ms_addr;
    logic [63:0]   mf_wd;
    logic [SW-1:0] ms_wd;
    bit            e_cv, e_dv, e_dw;
    int            e_ct, e_dt;
    logic [63:0]   e_cd;
    logic [LINEW-1:0] e_dl;
    int            fpend[$], spend[$];
    bit            sb_act, hold;
    int            sb_tag, sb_beat;
    int            miss_pct, wr_pct, rdy_pct;
    bit            last_ready;

    task automatic cycle();
        int free_i;
        bit e_rdy, n_dv, n_dw;
        int n_dt;
        logic [LINEW-1:0] n_dl;
        @(negedge clk);
        // stimulus
        miss_valid = ($urandom % 100) < miss_pct;
        miss_write = ($urandom % 100) < wr_pct;
        miss_addr  = {$urandom, $urandom} & {AW{1'b1}};
        for (int i = 0; i < 16; i++) miss_wdata[i*32 +: 32] = $urandom;
        fast_req_ready = ($urandom % 100) < rdy_pct;
        slow_req_ready = ($urandom % 100) < rdy_pct;
        fast_rsp_valid = 0; fast_rsp_tag = '0; fast_rsp_data = '0;
        if (!hold && fpend.size() > 0 && ($urandom % 3) == 0) begin
            int k = $urandom % fpend.size();
            int t = fpend[k];
            fpend.delete(k);
            fast_rsp_valid = 1; fast_rsp_tag = TW'(t); fast_rsp_data = pat(m_addr[t], 0);
        end
        if (!sb_act && !hold && spend.size() > 0 && ($urandom % 2) == 0) begin
            int k = $urandom % spend.size();
            sb_tag = spend[k];
            spend.delete(k);
            sb_act = 1; sb_beat = 0;
        end
        slow_rsp_valid = 0; slow_rsp_tag = '0; slow_rsp_data = '0;
        if (sb_act) begin
            slow_rsp_valid = 1; slow_rsp_tag = TW'(sb_tag);
            slow_rsp_data = pat(m_addr[sb_tag], sb_beat + 1); // R4 beat k is word k+1
        end
        #1;
        // compare
        free_i = -1;
        for (int i = NT - 1; i >= 0; i--) if (!m_busy[i]) free_i = i;
        e_rdy = (free_i >= 0) && (!mf_vld || fast_req_ready) && (!ms_vld || slow_req_ready);
        last_ready = miss_ready;
        chk(miss_ready === e_rdy, "R8 miss_ready", LINEW'(miss_ready), LINEW'(e_rdy));
        if (free_i >= 0) chk(miss_tag === TW'(free_i), "R9 miss_tag", LINEW'(miss_tag), LINEW'(free_i));
        chk(fast_req_valid === mf_vld, "R1 fast_req_valid", LINEW'(fast_req_valid), LINEW'(mf_vld));
        if (mf_vld)
            chk({fast_req_write, fast_req_tag, fast_req_addr, fast_req_wdata} === {mf_wr, TW'(mf_tag), mf_addr, mf_wd},
                "R1 fast request fields", LINEW'({fast_req_write, fast_req_tag, fast_req_addr, fast_req_wdata}),
                LINEW'({mf_wr, TW'(mf_tag), mf_addr, mf_wd}));
        chk(slow_req_valid === ms_vld, "R2 slow_req_valid", LINEW'(slow_req_valid), LINEW'(ms_vld));
        if (ms_vld)
            chk({slow_req_write, slow_req_tag, slow_req_addr, slow_req_wdata} === {ms_wr, TW'(ms_tag), ms_addr, ms_wd},
                "R2 slow request fields", LINEW'({slow_req_write, slow_req_tag, slow_req_addr, slow_req_wdata}),
                LINEW'({ms_wr, TW'(ms_tag), ms_addr, ms_wd}));
        chk(crit_valid === e_cv, "R3 crit_valid", LINEW'(crit_valid), LINEW'(e_cv));
        if (e_cv)
            chk({crit_tag, crit_data} === {TW'(e_ct), e_cd}, "R3 crit tag/data",
                LINEW'({crit_tag, crit_data}), LINEW'({TW'(e_ct), e_cd}));
        chk(done_valid === e_dv, "R5 R7 done_valid", LINEW'(done_valid), LINEW'(e_dv));
        if (e_dv) begin
            chk(done_tag === TW'(e_dt), "R6 R11 done_tag", LINEW'(done_tag), LINEW'(e_dt));
            chk(done_write === e_dw, "R7 done_write", LINEW'(done_write), LINEW'(e_dw));
            chk(done_line === e_dl, "R4 R5 done_line", done_line, e_dl);
        end
        // advance model
        n_dv = 0; n_dt = 0; n_dw = 0; n_dl = '0;
        for (int i = 0; i < NT; i++) begin
            if (!n_dv && m_busy[i] && m_fd[i] && m_sd[i]) begin
                n_dv = 1; n_dt = i; n_dw = m_wr[i];
                n_dl = m_wr[i] ? '0 : line_of(m_addr[i]);
                m_busy[i] = 0; m_fd[i] = 0; m_sd[i] = 0;
            end
        end
        if (mf_vld && fast_req_ready) begin
            if (mf_wr) m_fd[mf_tag] = 1; else fpend.push_back(mf_tag);
            mf_vld = 0;
        end
        if (ms_vld && slow_req_ready) begin
            if (ms_wr) m_sd[ms_tag] = 1; else spend.push_back(ms_tag);
            ms_vld = 0;
        end
        if (miss_valid && e_rdy) begin
            m_busy[free_i] = 1; m_wr[free_i] = miss_write; m_fd[free_i] = 0; m_sd[free_i] = 0;
            m_addr[free_i] = miss_addr;
            mf_vld = 1; mf_wr = miss_write; mf_tag = free_i; mf_addr = miss_addr; mf_wd = miss_wdata[63:0];
            ms_vld = 1; ms_wr = miss_write; ms_tag = free_i; ms_addr = miss_addr; ms_wd = miss_wdata[LINEW-1:64];
        end
        e_cv = fast_rsp_valid;
        if (fast_rsp_valid) begin
            e_ct = int'(fast_rsp_tag); e_cd = fast_rsp_data; m_fd[fast_rsp_tag] = 1;
        end
        if (sb_act) begin
            if (sb_beat == 6) begin m_sd[sb_tag] = 1; sb_act = 0; end
            else sb_beat++;
        end
        e_dv = n_dv; e_dt = n_dt; e_dw = n_dw; e_dl = n_dl;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    initial begin
        bit all_busy, any_busy;
        rst_n = 0; miss_valid = 0; miss_write = 0; miss_addr = '0; miss_wdata = '0;
        fast_req_ready = 0; slow_req_ready = 0;
        fast_rsp_valid = 0; fast_rsp_tag = '0; fast_rsp_data = '0;
        slow_rsp_valid = 0; slow_rsp_tag = '0; slow_rsp_data = '0;
        for (int i = 0; i < NT; i++) begin m_busy[i] = 0; m_wr[i] = 0; m_fd[i] = 0; m_sd[i] = 0; m_addr[i] = '0; end
        mf_vld = 0; ms_vld = 0; e_cv = 0; e_dv = 0; sb_act = 0; hold = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        #1;
        // R10 reset state
        chk({fast_req_valid, slow_req_valid, crit_valid, done_valid} === 4'b0, "R10 no valid after reset",
            LINEW'({fast_req_valid, slow_req_valid, crit_valid, done_valid}), '0);
        chk(miss_ready === 1'b1, "R10 miss_ready after reset", LINEW'(miss_ready), LINEW'(1));

        // Fill the table with reads while responses are held back (R8)
        hold = 1; miss_pct = 100; wr_pct = 0; rdy_pct = 100;
        run(20);
        all_busy = 1;
        for (int i = 0; i < NT; i++) all_busy &= m_busy[i];
        chk(all_busy && last_ready == 0, "R8 table full blocks misses", LINEW'(last_ready), '0);

        // Release: out-of-order responses drain the table (R6)
        hold = 0; miss_pct = 0;
        run(300);

        // Mixed traffic with random backpressure
        miss_pct = 50; wr_pct = 40; rdy_pct = 70;
        run(4000);
        miss_pct = 80; wr_pct = 30; rdy_pct = 30;
        run(1000);

        // Drain
        miss_pct = 0; rdy_pct = 100;
        run(600);
        any_busy = 0;
        for (int i = 0; i < NT; i++) any_busy |= m_busy[i];
        chk(!any_busy && last_ready == 1, "R8 all tags free after drain", LINEW'(last_ready), LINEW'(1));

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule